// File: doc/BRIEF.md
# Vector Branch-Condition Sequencer

This block evaluates one conditional branch against a vector of 4-bit condition fields. It handles one element per clock. Each element yields a pass/fail result. The per-element results are folded into a single branch decision, either by AND or by OR. The loop can end early as soon as the decision can no longer change.

Along the way the block can count the count register (CTR) down. It can also shorten the vector length when an element test matches a chosen polarity. Once the loop ends, it computes the next instruction address and decides whether the link register is written.

Operation starts with a one-cycle `start` pulse while the block is idle. All operands are captured at that edge. The results are valid during the single cycle in which `done` is high.

Top module: `vbr_seq`

## Requirements
- R1: `mode_sel` selects the mode. Bit 0 enables length truncation and bit 1 enables CTR-test counting: 00 is plain, 01 is truncation, 10 is CTR-test, and 11 is both.
- R2: For an active element i, the test bit is bit `bi` of field i, which is `crf[4*i+bi]`. The element condition is `bo[0] | ~(testbit ^ bo[1])`.
- R3: An element with `pred[i]`=0 is handled according to `m_sz`. With `m_sz`=0 it is skipped: it takes no part in the decision or in truncation, and it decrements CTR only when `bo[2]`=0, CTR-test is on and `m_cti`=0. With `m_sz`=1 its test bit is `m_snz`.
- R4: For an active element, CTR is decremented when `bo[2]`=0, unless CTR-test is on and (condition XOR `m_cti`) is 1. Then ctr_ok = `bo[2] | ((CTR after this element != 0) ^ bo[3])`. `ctr_out` holds the final count, and `ctr_we` is 1 when at least one decrement happened.
- R5: In truncation mode, the loop stops at once when `m_vsb` equals (condition AND ctr_ok). `vl_out` then becomes i+1 if `m_vli`=1, or i if `m_vli`=0, and `vl_we`=1. Otherwise `vl_out` equals `vl_in` and `vl_we`=0.
- R6: The decision starts at `m_all`. Each active element's (condition AND ctr_ok) is ANDed into it when `m_all`=1 and ORed into it when `m_all`=0. The loop stops after the first active element whose result differs from `m_all`. `taken` is the final decision.
- R7: With `crf_scalar`=1, the loop stops after element 0.
- R8: The link flag starts as `lk` and is inverted when `taken` and `m_lru` are both 1. When the flag is 1, `lr_we`=1 and `lr_out` = `cia`+4. Otherwise `lr_we`=0 and `lr_out` = `lr_in`.
- R9: Let off be `bd` sign-extended and shifted left by 2. When taken, `nia` is off if `aa`=1 and `cia`+off if `aa`=0. When not taken, `nia` is `cia`+4.
- R10: With `vl_in`=0, no element is tested: `done` rises in the cycle right after the start edge, and `taken`=`m_all`.
- R11: After reset `done` is 0. Otherwise `done` is high for exactly one cycle, at the end of the cycle that follows the start edge plus one cycle for each element visited.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin evaluation (sampled when idle) |
| mode_sel | input | 2 | Mode select |
| m_all | input | 1 | AND-fold (1) or OR-fold (0) |
| m_snz | input | 1 | Test bit substituted for masked elements when zeroing |
| m_cti | input | 1 | CTR-test inversion |
| m_vsb | input | 1 | Truncation polarity |
| m_vli | input | 1 | Truncated length includes current element |
| m_lru | input | 1 | Link update conditional on outcome |
| m_sz | input | 1 | Masked elements use m_snz instead of being skipped |
| bo | input | 4 | Branch options |
| bi | input | 2 | Bit select within a field |
| aa | input | 1 | Absolute target |
| lk | input | 1 | Link request |
| bd | input | BD_W | Branch displacement (word units) |
| cia | input | ADDR_W | Current instruction address |
| pred | input | MAX_VL | Predicate mask |
| crf | input | 4*MAX_VL | Condition fields, field i at bits 4i+3..4i |
| vl_in | input | VL_W | Vector length |
| crf_scalar | input | 1 | Condition operand is scalar |
| ctr_in | input | CTR_W | Count register |
| lr_in | input | ADDR_W | Link register |
| done | output | 1 | Results valid |
| taken | output | 1 | Branch decision |
| nia | output | ADDR_W | Next instruction address |
| ctr_out | output | CTR_W | Updated count |
| ctr_we | output | 1 | Count write enable |
| lr_out | output | ADDR_W | Link value |
| lr_we | output | 1 | Link write enable |
| vl_out | output | VL_W | Possibly truncated length |
| vl_we | output | 1 | Length write enable |

## Verification
All results appear together with `done`. That is one edge after the start edge for each element visited, and immediately after the start edge when the length is zero. The bench models the element loop in arithmetic and from it derives both the number of visited elements and every output value. After raising `start`, it counts clock edges, sampling one time unit after each edge, until `done` shows. It compares that count with the number of visited elements before comparing any result. The next operation is launched only after one more edge, when the block is idle again.

// File: rtl/vbr_pkg.sv
package vbr_pkg;

    typedef struct packed {
        logic all;
        logic snz;
        logic cti;
        logic vsb;
        logic vli;
        logic lru;
        logic sz;
    } vbr_mode_t;

    typedef struct packed {
        logic [3:0] bo;
        logic [1:0] bi;
        logic       aa;
        logic       lk;
        logic       scalar;
        logic       vlset;
        logic       ctest;
    } vbr_op_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } vbr_state_t;

    function automatic logic elem_cond(input logic [3:0] bo, input logic tbit);
        return bo[0] | ~(tbit ^ bo[1]);
    endfunction

endpackage

// File: rtl/vbr_elem.sv
module vbr_elem
    import vbr_pkg::*;
#(
    parameter int CTR_W = 16
) (
    input  vbr_mode_t        md,
    input  vbr_op_t          op,
    input  logic [3:0]       fld,
    input  logic             pbit,
    input  logic [CTR_W-1:0] ctr_cur,
    input  logic             acc_cur,
    output logic             skip,
    output logic             dec,
    output logic [CTR_W-1:0] ctr_nxt,
    output logic             acc_nxt,
    output logic             vl_hit,
    output logic             early
);
    logic tbit;
    logic cond;
    logic ctr_ok;
    logic res;

    always_comb begin
        skip    = ~pbit & ~md.sz;
        tbit    = pbit ? fld[op.bi] : md.snz;
        cond    = elem_cond(op.bo, tbit);
        if (skip)
            dec = ~op.bo[2] & op.ctest & ~md.cti;
        else
            dec = ~op.bo[2] & ~(op.ctest & (cond ^ md.cti));
        ctr_nxt = dec ? ctr_cur - 1'b1 : ctr_cur;
        ctr_ok  = op.bo[2] | ((ctr_nxt != '0) ^ op.bo[3]);
        res     = cond & ctr_ok;
        if (skip)
            acc_nxt = acc_cur;
        else if (md.all)
            acc_nxt = acc_cur & res;
        else
            acc_nxt = acc_cur | res;
        vl_hit  = ~skip & op.vlset & (md.vsb == res);
        early   = ~skip & (res != md.all);
    end
endmodule

// File: rtl/vbr_link.sv
module vbr_link #(
    parameter int ADDR_W = 32,
    parameter int BD_W   = 14
) (
    input  logic              taken,
    input  logic              aa,
    input  logic              lk,
    input  logic              lru,
    input  logic [BD_W-1:0]   bd,
    input  logic [ADDR_W-1:0] cia,
    input  logic [ADDR_W-1:0] lr_cur,
    output logic [ADDR_W-1:0] nia,
    output logic [ADDR_W-1:0] lr_new,
    output logic              lr_we
);
    localparam int EXT_W = ADDR_W - BD_W - 2;

    logic [ADDR_W-1:0] off;
    logic [ADDR_W-1:0] seq;
    logic              lflag;

    always_comb begin
        off   = {{EXT_W{bd[BD_W-1]}}, bd, 2'b00};
        seq   = cia + ADDR_W'(4);
        if (!taken)
            nia = seq;
        else if (aa)
            nia = off;
        else
            nia = cia + off;
        lflag  = lk ^ (taken & lru);
        lr_we  = lflag;
        lr_new = lflag ? seq : lr_cur;
    end
endmodule

// File: rtl/vbr_seq.sv
module vbr_seq
    import vbr_pkg::*;
#(
    parameter int MAX_VL = 8,
    parameter int CTR_W  = 16,
    parameter int ADDR_W = 32,
    parameter int BD_W   = 14,
    localparam int VL_W  = $clog2(MAX_VL + 1),
    localparam int IDX_W = (MAX_VL > 1) ? $clog2(MAX_VL) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic [1:0]            mode_sel,
    input  logic                  m_all,
    input  logic                  m_snz,
    input  logic                  m_cti,
    input  logic                  m_vsb,
    input  logic                  m_vli,
    input  logic                  m_lru,
    input  logic                  m_sz,
    input  logic [3:0]            bo,
    input  logic [1:0]            bi,
    input  logic                  aa,
    input  logic                  lk,
    input  logic [BD_W-1:0]       bd,
    input  logic [ADDR_W-1:0]     cia,
    input  logic [MAX_VL-1:0]     pred,
    input  logic [4*MAX_VL-1:0]   crf,
    input  logic [VL_W-1:0]       vl_in,
    input  logic                  crf_scalar,
    input  logic [CTR_W-1:0]      ctr_in,
    input  logic [ADDR_W-1:0]     lr_in,
    output logic                  done,
    output logic                  taken,
    output logic [ADDR_W-1:0]     nia,
    output logic [CTR_W-1:0]      ctr_out,
    output logic                  ctr_we,
    output logic [ADDR_W-1:0]     lr_out,
    output logic                  lr_we,
    output logic [VL_W-1:0]       vl_out,
    output logic                  vl_we
);
    vbr_state_t           st;
    vbr_mode_t            md_q;
    vbr_op_t              op_q;
    logic [BD_W-1:0]      bd_q;
    logic [ADDR_W-1:0]    cia_q;
    logic [ADDR_W-1:0]    lr_q;
    logic [MAX_VL-1:0]    pred_q;
    logic [4*MAX_VL-1:0]  crf_q;
    logic [VL_W-1:0]      vl_q;
    logic [VL_W-1:0]      idx;
    logic                 acc_q;
    logic [CTR_W-1:0]     ctr_q;
    logic                 dec_any;
    logic [VL_W-1:0]      vl_res;
    logic                 vl_we_q;

    logic [3:0]           fld_arr [MAX_VL];
    logic [IDX_W-1:0]     sel;
    logic                 e_skip, e_dec, e_acc, e_vlhit, e_early;
    logic [CTR_W-1:0]     e_ctr;
    logic                 last;
    logic                 stop;
    logic [VL_W-1:0]      idx_inc;

    genvar g;
    generate
        for (g = 0; g < MAX_VL; g++) begin : g_fld
            assign fld_arr[g] = crf_q[4*g +: 4];
        end
    endgenerate

    assign sel     = idx[IDX_W-1:0];
    assign idx_inc = idx + 1'b1;
    assign last    = (idx_inc == vl_q);
    assign stop    = e_vlhit | e_early | op_q.scalar | last;

    vbr_elem #(.CTR_W(CTR_W)) u_elem (
        .md      (md_q),
        .op      (op_q),
        .fld     (fld_arr[sel]),
        .pbit    (pred_q[sel]),
        .ctr_cur (ctr_q),
        .acc_cur (acc_q),
        .skip    (e_skip),
        .dec     (e_dec),
        .ctr_nxt (e_ctr),
        .acc_nxt (e_acc),
        .vl_hit  (e_vlhit),
        .early   (e_early)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            md_q    <= '0;
            op_q    <= '0;
            bd_q    <= '0;
            cia_q   <= '0;
            lr_q    <= '0;
            pred_q  <= '0;
            crf_q   <= '0;
            vl_q    <= '0;
            idx     <= '0;
            acc_q   <= 1'b0;
            ctr_q   <= '0;
            dec_any <= 1'b0;
            vl_res  <= '0;
            vl_we_q <= 1'b0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (start) begin
                        md_q    <= '{all: m_all, snz: m_snz, cti: m_cti, vsb: m_vsb,
                                     vli: m_vli, lru: m_lru, sz: m_sz};
                        op_q    <= '{bo: bo, bi: bi, aa: aa, lk: lk, scalar: crf_scalar,
                                     vlset: mode_sel[0], ctest: mode_sel[1]};
                        bd_q    <= bd;
                        cia_q   <= cia;
                        lr_q    <= lr_in;
                        pred_q  <= pred;
                        crf_q   <= crf;
                        vl_q    <= vl_in;
                        idx     <= '0;
                        acc_q   <= m_all;
                        ctr_q   <= ctr_in;
                        dec_any <= 1'b0;
                        vl_res  <= vl_in;
                        vl_we_q <= 1'b0;
                        st      <= (vl_in == '0) ? ST_FIN : ST_RUN;
                    end
                end
                ST_RUN: begin
                    ctr_q <= e_ctr;
                    acc_q <= e_acc;
                    if (e_dec)
                        dec_any <= 1'b1;
                    if (e_vlhit) begin
                        vl_res  <= md_q.vli ? idx_inc : idx;
                        vl_we_q <= 1'b1;
                    end
                    if (stop)
                        st <= ST_FIN;
                    else
                        idx <= idx_inc;
                end
                ST_FIN: st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    vbr_link #(.ADDR_W(ADDR_W), .BD_W(BD_W)) u_link (
        .taken  (acc_q),
        .aa     (op_q.aa),
        .lk     (op_q.lk),
        .lru    (md_q.lru),
        .bd     (bd_q),
        .cia    (cia_q),
        .lr_cur (lr_q),
        .nia    (nia),
        .lr_new (lr_out),
        .lr_we  (lr_we)
    );

    assign done    = (st == ST_FIN);
    assign taken   = acc_q;
    assign ctr_out = ctr_q;
    assign ctr_we  = dec_any;
    assign vl_out  = vl_res;
    assign vl_we   = vl_we_q;
endmodule

// File: rtl/vbr_seq_chk.sv
module vbr_seq_chk
    import vbr_pkg::*;
#(
    parameter int CTR_W  = 16,
    parameter int ADDR_W = 32,
    parameter int VL_W   = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input vbr_state_t        st,
    input logic [VL_W-1:0]   vl_in,
    input logic [VL_W-1:0]   vl_q,
    input logic [ADDR_W-1:0] cia_q,
    input logic [CTR_W-1:0]  ctr_q_in,
    input logic              done,
    input logic              taken,
    input logic [ADDR_W-1:0] nia,
    input logic [ADDR_W-1:0] lr_out,
    input logic              lr_we,
    input logic [CTR_W-1:0]  ctr_out,
    input logic              ctr_we,
    input logic [VL_W-1:0]   vl_out,
    input logic              vl_we
);
    logic [CTR_W-1:0] ctr_start;

    always_ff @(posedge clk) begin
        if (rst)
            ctr_start <= '0;
        else if (st == ST_IDLE && start)
            ctr_start <= ctr_q_in;
    end

    a_r11_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r10_zero_len: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && start && vl_in == '0) |=> done);

    a_r8_link_value: assert property (@(posedge clk) disable iff (rst)
        (done && lr_we) |-> (lr_out == cia_q + ADDR_W'(4)));

    a_r9_fallthrough: assert property (@(posedge clk) disable iff (rst)
        (done && !taken) |-> (nia == cia_q + ADDR_W'(4)));

    a_r5_len_bound: assert property (@(posedge clk) disable iff (rst)
        (done && vl_we) |-> (vl_out <= vl_q));

    a_r5_len_kept: assert property (@(posedge clk) disable iff (rst)
        (done && !vl_we) |-> (vl_out == vl_q));

    a_r4_ctr_moved: assert property (@(posedge clk) disable iff (rst)
        (done && ctr_we) |-> (ctr_out != ctr_start));

    a_r4_ctr_held: assert property (@(posedge clk) disable iff (rst)
        (done && !ctr_we) |-> (ctr_out == ctr_start));
endmodule

bind vbr_seq vbr_seq_chk #(.CTR_W(CTR_W), .ADDR_W(ADDR_W), .VL_W(VL_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .st       (st),
    .vl_in    (vl_in),
    .vl_q     (vl_q),
    .cia_q    (cia_q),
    .ctr_q_in (ctr_in),
    .done     (done),
    .taken    (taken),
    .nia      (nia),
    .lr_out   (lr_out),
    .lr_we    (lr_we),
    .ctr_out  (ctr_out),
    .ctr_we   (ctr_we),
    .vl_out   (vl_out),
    .vl_we    (vl_we)
);

// File: tb/sim_vbr_seq.sv
module sim_vbr_seq;
    localparam int CLK_P  = 10;
    localparam int MAX_VL = 8;
    localparam int CTR_W  = 16;
    localparam int ADDR_W = 32;
    localparam int BD_W   = 14;
    localparam int VL_W   = $clog2(MAX_VL + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [1:0] mode_sel = '0;
    logic m_all = 0, m_snz = 0, m_cti = 0, m_vsb = 0, m_vli = 0, m_lru = 0, m_sz = 0;
    logic [3:0] bo = '0;
    logic [1:0] bi = '0;
    logic aa = 0, lk = 0, crf_scalar = 0;
    logic [BD_W-1:0] bd = '0;
    logic [ADDR_W-1:0] cia = '0, lr_in = '0;
    logic [MAX_VL-1:0] pred = '0;
    logic [4*MAX_VL-1:0] crf = '0;
    logic [VL_W-1:0] vl_in = '0;
    logic [CTR_W-1:0] ctr_in = '0;

    logic done, taken, ctr_we, lr_we, vl_we;
    logic [ADDR_W-1:0] nia, lr_out;
    logic [CTR_W-1:0] ctr_out;
    logic [VL_W-1:0] vl_out;

    int n_chk = 0;
    int n_bad = 0;

    logic e_taken, e_ctr_we, e_lr_we, e_vl_we;
    logic [ADDR_W-1:0] e_nia, e_lr;
    logic [CTR_W-1:0] e_ctr;
    logic [VL_W-1:0] e_vl;
    int e_cyc;

    always #(CLK_P/2) clk = ~clk;

    vbr_seq #(.MAX_VL(MAX_VL), .CTR_W(CTR_W), .ADDR_W(ADDR_W), .BD_W(BD_W)) u0 (
        .clk(clk), .rst(rst), .start(start), .mode_sel(mode_sel),
        .m_all(m_all), .m_snz(m_snz), .m_cti(m_cti), .m_vsb(m_vsb),
        .m_vli(m_vli), .m_lru(m_lru), .m_sz(m_sz),
        .bo(bo), .bi(bi), .aa(aa), .lk(lk), .bd(bd), .cia(cia),
        .pred(pred), .crf(crf), .vl_in(vl_in), .crf_scalar(crf_scalar),
        .ctr_in(ctr_in), .lr_in(lr_in),
        .done(done), .taken(taken), .nia(nia), .ctr_out(ctr_out), .ctr_we(ctr_we),
        .lr_out(lr_out), .lr_we(lr_we), .vl_out(vl_out), .vl_we(vl_we)
    );

    task automatic check(input string req, input string scen, input logic [63:0] got,
                         input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s (%s): got %0h expected %0h", req, scen, got, exp);
        end
    endtask

    task automatic model();
        logic acc, tb, c, d, cok, e;
        logic [CTR_W-1:0] ctr;
        logic [ADDR_W-1:0] off;
        acc = m_all; ctr = ctr_in; e_ctr_we = 0; e_vl_we = 0; e_vl = vl_in; e_cyc = 0;
        for (int i = 0; i < int'(vl_in); i++) begin
            e_cyc = i + 1;
            if (!pred[i] && !m_sz) begin
                if (!bo[2] && mode_sel[1] && !m_cti) begin ctr = ctr - 1; e_ctr_we = 1; end
                if (crf_scalar) break;
                continue;
            end
            tb  = pred[i] ? crf[4*i + int'(bi)] : m_snz;
            c   = bo[0] | ~(tb ^ bo[1]);
            d   = !bo[2] && !(mode_sel[1] && (c ^ m_cti));
            if (d) begin ctr = ctr - 1; e_ctr_we = 1; end
            cok = bo[2] | ((ctr != 0) ^ bo[3]);
            e   = c & cok;
            acc = m_all ? (acc & e) : (acc | e);
            if (mode_sel[0] && (m_vsb == e)) begin
                e_vl_we = 1;
                e_vl = m_vli ? VL_W'(i + 1) : VL_W'(i);
                break;
            end
            if (e != m_all) break;
            if (crf_scalar) break;
        end
        e_taken = acc;
        e_ctr = ctr;
        off = {{(ADDR_W-BD_W-2){bd[BD_W-1]}}, bd, 2'b00};
        e_nia = !acc ? cia + 4 : (aa ? off : cia + off);
        e_lr_we = lk ^ (acc & m_lru);
        e_lr = e_lr_we ? cia + 4 : lr_in;
    endtask

    task automatic run(input string scen);
        int cyc;
        model();
        @(negedge clk);
        start = 1'b1;
        @(posedge clk);
        #1 start = 1'b0;
        cyc = 0;
        while (!done && cyc < 40) begin
            @(posedge clk);
            #1 cyc++;
        end
        check("R11", scen, 64'(cyc), 64'(e_cyc));
        check("R6", scen, 64'(taken), 64'(e_taken));
        check("R9", scen, 64'(nia), 64'(e_nia));
        check("R4", scen, 64'(ctr_out), 64'(e_ctr));
        check("R4", scen, 64'(ctr_we), 64'(e_ctr_we));
        check("R8", scen, 64'(lr_we), 64'(e_lr_we));
        check("R8", scen, 64'(lr_out), 64'(e_lr));
        check("R5", scen, 64'(vl_we), 64'(e_vl_we));
        check("R5", scen, 64'(vl_out), 64'(e_vl));
        @(posedge clk);
    endtask

    task automatic base();
        mode_sel = 2'b00; m_all = 0; m_snz = 0; m_cti = 0; m_vsb = 0; m_vli = 0;
        m_lru = 0; m_sz = 0; bo = 4'b0100; bi = 2'd0; aa = 0; lk = 0;
        bd = 14'h0010; cia = 32'h0000_1000; lr_in = 32'hDEAD_0000;
        pred = '1; crf = '0; vl_in = 4; crf_scalar = 0; ctr_in = 16'd10;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        check("R11", "reset", 64'(done), 64'd0);

        base(); vl_in = 0; m_all = 1; run("R10 zero length AND");
        base(); vl_in = 0; m_all = 0; lk = 1; run("R10 zero length OR");
        base(); bi = 2'd2; bo = 4'b0110; crf = 32'h0000_4000; run("R2 bit select");
        base(); pred = 8'b1111_0101; m_sz = 0; bo = 4'b0010; crf = 32'h0000_0000;
            mode_sel = 2'b10; run("R3 skip with CTR-test");
        base(); pred = 8'b0000_0000; m_sz = 1; m_snz = 1; bo = 4'b0110; run("R3 zeroing");
        base(); mode_sel = 2'b10; m_cti = 1; bo = 4'b0010; crf = 32'h0101_0101;
            vl_in = 8; run("R4 CTR-test inverted");
        base(); mode_sel = 2'b01; m_vsb = 1; m_vli = 1; bo = 4'b0110; crf = 32'h0000_1000;
            vl_in = 8; run("R5 truncate inclusive");
        base(); mode_sel = 2'b11; m_vsb = 0; m_vli = 0; m_all = 1; bo = 4'b0110;
            crf = 32'h0000_0111; vl_in = 8; run("R1 combined mode");
        base(); crf_scalar = 1; vl_in = 8; bo = 4'b0110; crf = 32'h1; run("R7 scalar");
        base(); bo = 4'b0110; crf = 32'h0001_0000; vl_in = 8; lk = 1; m_lru = 1;
            aa = 1; bd = 14'h3FF0; run("R8 R9 absolute negative");

        for (int t = 0; t < 3000; t++) begin
            mode_sel = 2'($urandom); m_all = 1'($urandom); m_snz = 1'($urandom);
            m_cti = 1'($urandom); m_vsb = 1'($urandom); m_vli = 1'($urandom);
            m_lru = 1'($urandom); m_sz = 1'($urandom);
            bo = 4'($urandom); bi = 2'($urandom); aa = 1'($urandom); lk = 1'($urandom);
            bd = BD_W'($urandom); cia = {$urandom, 2'b00} >> 2 << 2;
            lr_in = $urandom; pred = ($urandom % 3 == 0) ? '1 : MAX_VL'($urandom);
            crf = 32'($urandom); vl_in = VL_W'($urandom % (MAX_VL + 1));
            crf_scalar = ($urandom % 6 == 0);
            ctr_in = ($urandom % 2) ? CTR_W'($urandom % 5) : CTR_W'($urandom);
            run("R1 R2 R3 sweep");
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_P * 150000);
        n_bad++;
        $display("FAIL R11 (watchdog): got hung expected done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule